// File: doc/BRIEF.md
# Shared-Function GPIO Port Multiplexer

This block controls one 8-pin general-purpose port whose pins are shared with on-chip peripherals. It keeps a data latch, a direction register and a small pad-configuration register. It then decides, pin by pin, who drives the pad. The upper four pins can be taken over by four PWM channels. Pin 3 carries a timer compare output whenever it is configured as an output. Pins 2 to 0 form a three-wire serial link (clock, data out, data in) while that link is enabled.

For each pin the block produces an output enable, an output value, a P-channel drive enable (low selects open-drain) and a pull-up enable for the pad cell. It also builds the CPU read value of the port from the latch and from pin levels that pass through a synchronizer. The peripherals supply only their enable and data signals. The pad cells and the bus decoding are outside this block.

Top module: `shared_port_mux`

## Requirements
- R1: While `rst_n` is low, and after it is released, the latch, the direction register and all four configuration bits are 0. Every `pad_oe`, `pad_out`, `pad_pdrv_en` and `pad_pu_en` bit is therefore 0.
- R2: On a clock edge with `wr_en` high, `wr_addr` 0 loads the data latch from `wr_data` and `wr_addr` 1 loads the direction register (1 = output). `wr_addr` 2 loads the configuration bits: `wr_data[0]` open-drain upper, `[1]` open-drain lower, `[2]` pull-up upper, `[3]` pull-up lower.
- R3: For k in 0..3, while `pwm_en[k]` is 1, pin 4+k is an output that carries `pwm_out[k]`, whatever its direction bit says.
- R4: For every pin except 3, `port_rd` returns the latch bit when the direction bit is 1 and the synchronized pin level when it is 0. This holds even while a peripheral owns the pin.
- R5: When direction bit 3 is 1, pin 3 is an output that drives `tmr_cmp`, never the latch bit.
- R6: `port_rd[3]` always returns the synchronized level of pin 3, whatever direction bit 3 says.
- R7: While `ser_en` is 1, pin 1 is an output that drives `ser_sdo`, and pin 0 is an input. The synchronized level of pin 0 appears on `ser_sdi`. While `ser_en` is 0, pins 2 to 0 follow their direction bits.
- R8: While `ser_en` is 1, pin 2 drives `ser_sck_out` when `ser_master` is 1 and is an input when it is 0. Its synchronized level appears on `ser_sck_in`.
- R9: `pad_pdrv_en` is 1 only on output pins. It is 0 on pins 7 to 4 while open-drain upper is set, and 0 on pins 3 to 0 while open-drain lower is set. This applies to GPIO and peripheral outputs alike.
- R10: `pad_pu_en` follows pull-up upper for pins 7 to 4 and pull-up lower for pins 3 to 0. It is forced to 0 on any pin that is an output driving 0.
- R11: A change on `pad_in` reaches `port_rd`, `ser_sdi` and `ser_sck_in` after exactly two rising clock edges.
- R12: `pad_out` is 0 on every pin whose `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 latch, 1 direction, 2 configuration |
| wr_data | input | 8 | Write data |
| port_rd | output | 8 | CPU read value of the port |
| pwm_en | input | 4 | PWM channel enables, channel k on pin 4+k |
| pwm_out | input | 4 | PWM channel outputs |
| tmr_cmp | input | 1 | Timer compare output |
| ser_en | input | 1 | Serial link enable |
| ser_master | input | 1 | Serial link is master (drives the clock) |
| ser_sck_out | input | 1 | Serial clock from the link in master mode |
| ser_sdo | input | 1 | Serial data out from the link |
| ser_sck_in | output | 1 | Synchronized level of pin 2 |
| ser_sdi | output | 1 | Synchronized level of pin 0 |
| pad_in | input | 8 | Pin levels from the pad cells |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pdrv_en | output | 8 | Per-pin P-channel drive enable |
| pad_pu_en | output | 8 | Per-pin pull-up enable |

## Verification
The pad controls are combinational from the registers and the peripheral inputs. A register write therefore shows on `pad_oe`, `pad_out`, `pad_pdrv_en` and `pad_pu_en` straight after the edge that captures it, and a peripheral input change shows within the same cycle. Pin levels reach the read value only after two edges. The bench sets all inputs on a falling edge, lets several edges pass before it compares a vector, and reads the outputs on a later falling edge. For the latency check it samples `port_rd` after one edge, when the old value is still expected, and again after two edges, when the new value is expected.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;
    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_LATCH = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DIR   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CFG   = 2'd2;

    // configuration bit positions inside wr_data for ADR_CFG
    localparam int CFG_OD_HI = 0;
    localparam int CFG_OD_LO = 1;
    localparam int CFG_PU_HI = 2;
    localparam int CFG_PU_LO = 3;

    // pin roles
    localparam int PIN_TMR  = 3;
    localparam int PIN_SCK  = 2;
    localparam int PIN_SDO  = 1;
    localparam int PIN_SDI  = 0;
    localparam int PWM_BASE = NIB_W;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
        logic              od_hi;
        logic              od_lo;
        logic              pu_hi;
        logic              pu_lo;
    } port_cfg_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] pdrv;
        logic [PORT_W-1:0] pu;
    } pad_ctl_t;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
`timescale 1ns/1ps
module port_regs
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    output port_cfg_t         cfg
);
    port_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_LATCH: cfg_d.latch = wr_data;
                ADR_DIR:   cfg_d.dir   = wr_data;
                ADR_CFG: begin
                    cfg_d.od_hi = wr_data[CFG_OD_HI];
                    cfg_d.od_lo = wr_data[CFG_OD_LO];
                    cfg_d.pu_hi = wr_data[CFG_PU_HI];
                    cfg_d.pu_lo = wr_data[CFG_PU_LO];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_LATCH) |=> (cfg_q.latch == $past(wr_data))); // R2
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_DIR) |=> (cfg_q.dir == $past(wr_data))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/pin_route.sv
`timescale 1ns/1ps
module pin_route
    import gpio_mux_pkg::*;
(
    input  port_cfg_t         cfg,
    input  logic [NIB_W-1:0]  pwm_en,
    input  logic [NIB_W-1:0]  pwm_out,
    input  logic              tmr_cmp,
    input  logic              ser_en,
    input  logic              ser_master,
    input  logic              ser_sck_out,
    input  logic              ser_sdo,
    input  logic [PORT_W-1:0] pin_s,
    output pad_ctl_t          ctl,
    output logic [PORT_W-1:0] port_rd
);
    logic [PORT_W-1:0] oe_w, val_w, od_mask, pu_mask;

    always_comb begin
        oe_w  = cfg.dir;
        val_w = cfg.latch;
        for (int k = 0; k < NIB_W; k++) begin
            if (pwm_en[k]) begin
                oe_w[PWM_BASE+k]  = 1'b1;
                val_w[PWM_BASE+k] = pwm_out[k];
            end
        end
        val_w[PIN_TMR] = tmr_cmp;
        if (ser_en) begin
            oe_w[PIN_SCK]  = ser_master;
            val_w[PIN_SCK] = ser_sck_out;
            oe_w[PIN_SDO]  = 1'b1;
            val_w[PIN_SDO] = ser_sdo;
            oe_w[PIN_SDI]  = 1'b0;
        end
        od_mask = {{NIB_W{cfg.od_hi}}, {NIB_W{cfg.od_lo}}};
        pu_mask = {{NIB_W{cfg.pu_hi}}, {NIB_W{cfg.pu_lo}}};
        ctl.oe   = oe_w;
        ctl.out  = val_w & oe_w;
        ctl.pdrv = oe_w & ~od_mask;
        ctl.pu   = pu_mask & ~(oe_w & ~val_w);
        port_rd  = (cfg.dir & cfg.latch) | (~cfg.dir & pin_s);
        port_rd[PIN_TMR] = pin_s[PIN_TMR];
    end
endmodule

// File: rtl/shared_port_mux.sv
`timescale 1ns/1ps
module shared_port_mux
    import gpio_mux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] port_rd,
    input  logic [NIB_W-1:0]  pwm_en,
    input  logic [NIB_W-1:0]  pwm_out,
    input  logic              tmr_cmp,
    input  logic              ser_en,
    input  logic              ser_master,
    input  logic              ser_sck_out,
    input  logic              ser_sdo,
    output logic              ser_sck_in,
    output logic              ser_sdi,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pdrv_en,
    output logic [PORT_W-1:0] pad_pu_en
);
    port_cfg_t         cfg;
    pad_ctl_t          ctl;
    logic [PORT_W-1:0] pin_s;

    port_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_s)
    );

    pin_route u_route (
        .cfg         (cfg),
        .pwm_en      (pwm_en),
        .pwm_out     (pwm_out),
        .tmr_cmp     (tmr_cmp),
        .ser_en      (ser_en),
        .ser_master  (ser_master),
        .ser_sck_out (ser_sck_out),
        .ser_sdo     (ser_sdo),
        .pin_s       (pin_s),
        .ctl         (ctl),
        .port_rd     (port_rd)
    );

    assign pad_oe      = ctl.oe;
    assign pad_out     = ctl.out;
    assign pad_pdrv_en = ctl.pdrv;
    assign pad_pu_en   = ctl.pu;
    assign ser_sck_in  = pin_s[PIN_SCK];
    assign ser_sdi     = pin_s[PIN_SDI];

    AST_PWM_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe[PORT_W-1:PWM_BASE] & pwm_en) == pwm_en)); // R3
    AST_PU_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu_en & pad_oe & ~pad_out) == '0)); // R10
    AST_OD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.od_hi |-> (pad_pdrv_en[PORT_W-1:PWM_BASE] == '0)); // R9
    AST_SDI_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> !pad_oe[PIN_SDI]); // R7
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0)); // R12
    AST_TMR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[PIN_TMR] |-> (pad_out[PIN_TMR] == tmr_cmp)); // R5
endmodule

// File: tb/shared_port_mux_test.sv
`timescale 1ns/1ps
module shared_port_mux_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] port_rd;
    logic [3:0] pwm_en = '0, pwm_out = '0;
    logic       tmr_cmp = 1'b0, ser_en = 1'b0, ser_master = 1'b0;
    logic       ser_sck_out = 1'b0, ser_sdo = 1'b0;
    logic       ser_sck_in, ser_sdi;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pdrv_en, pad_pu_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    shared_port_mux uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_rd(port_rd), .pwm_en(pwm_en),
        .pwm_out(pwm_out), .tmr_cmp(tmr_cmp), .ser_en(ser_en),
        .ser_master(ser_master), .ser_sck_out(ser_sck_out),
        .ser_sdo(ser_sdo), .ser_sck_in(ser_sck_in), .ser_sdi(ser_sdi),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pdrv_en(pad_pdrv_en), .pad_pu_en(pad_pu_en)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] lat;
        logic [3:0] pen;
        logic [3:0] pout;
        logic       tmr;
        logic       sen;
        logic       smst;
        logic       sck;
        logic       sdo;
        logic [3:0] cfg;  // {pu_lo, pu_hi, od_lo, od_hi}
        logic [7:0] pin;
        logic [7:0] e_oe;
        logic [7:0] e_out;
        logic [7:0] e_pd;
        logic [7:0] e_pu;
        logic [7:0] e_rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // all outputs, plain GPIO
        '{8'hFF, 8'hA5, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00,
          8'hFF, 8'hA5, 8'hFF, 8'h00, 8'hA5},
        // all inputs, both pull-ups
        '{8'h00, 8'hFF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hC, 8'h3C,
          8'h00, 8'h00, 8'h00, 8'hFF, 8'h3C},
        // PWM on channels 0 and 2, channel 2 driving low
        '{8'h00, 8'h00, 4'h5, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hC, 8'hF0,
          8'h50, 8'h10, 8'h50, 8'hBF, 8'hF0},
        // all PWM, upper open-drain, upper reads latch
        '{8'hF0, 8'h90, 4'hF, 4'h6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1, 8'h0F,
          8'hF0, 8'h60, 8'h00, 8'h00, 8'h9F},
        // serial master, lower open-drain and pull-up
        '{8'h01, 8'h01, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 8'h0D,
          8'h06, 8'h04, 8'h00, 8'h0D, 8'h0D},
        // serial slave, timer compare on pin 3
        '{8'h08, 8'h00, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h8, 8'h00,
          8'h0A, 8'h0A, 8'h0A, 8'h0F, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // reset state (R1)
        pad_in = 8'hFF;
        idle(3);
        chk("R1 oe in reset", pad_oe, 8'h00);
        chk("R1 pu in reset", pad_pu_en, 8'h00);
        rst_n = 1'b1;
        idle(3);
        chk("R1 oe after reset", pad_oe, 8'h00);
        chk("R1 out after reset", pad_out, 8'h00);
        chk("R1 pdrv after reset", pad_pdrv_en, 8'h00);
        chk("R1 pu after reset", pad_pu_en, 8'h00);
        chk("R4 read pins after reset", port_rd, 8'hFF);

        // vector table
        for (int v = 0; v < NV; v++) begin
            wreg(2'd0, VECS[v].lat);
            wreg(2'd1, VECS[v].dir);
            wreg(2'd2, {4'h0, VECS[v].cfg});
            pwm_en = VECS[v].pen; pwm_out = VECS[v].pout;
            tmr_cmp = VECS[v].tmr; ser_en = VECS[v].sen;
            ser_master = VECS[v].smst; ser_sck_out = VECS[v].sck;
            ser_sdo = VECS[v].sdo; pad_in = VECS[v].pin;
            idle(3);
            chk($sformatf("R3 R5 R7 R8 oe vec%0d", v), pad_oe, VECS[v].e_oe);
            chk($sformatf("R3 R5 R12 out vec%0d", v), pad_out, VECS[v].e_out);
            chk($sformatf("R9 pdrv vec%0d", v), pad_pdrv_en, VECS[v].e_pd);
            chk($sformatf("R10 pu vec%0d", v), pad_pu_en, VECS[v].e_pu);
            chk($sformatf("R4 R6 rd vec%0d", v), port_rd, VECS[v].e_rd);
        end

        // back to plain GPIO
        pwm_en = '0; ser_en = 1'b0; ser_master = 1'b0; tmr_cmp = 1'b0;
        wreg(2'd2, 8'h00);
        wreg(2'd1, 8'h00);
        pad_in = 8'h00;
        idle(3);

        // R11: two-edge synchronizer latency
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        chk("R11 rd after one edge", port_rd, 8'h00);
        @(negedge clk);
        chk("R11 rd after two edges", port_rd, 8'h5A);

        // R2 / R12: latch write with direction 0 leaves pins undriven
        wreg(2'd0, 8'hC3);
        chk("R12 out with dir 0", pad_out, 8'h00);
        chk("R2 oe unchanged by latch write", pad_oe, 8'h00);
        wreg(2'd1, 8'hF7);
        chk("R2 R4 rd returns latch", port_rd, 8'hC3 & 8'hF7 | 8'h5A & 8'h08);

        // R5 / R6: pin 3 output drives timer, reads pin
        wreg(2'd0, 8'h08);
        wreg(2'd1, 8'h08);
        tmr_cmp = 1'b0;
        pad_in = 8'h08;
        idle(3);
        chk("R5 pin3 drives timer low", pad_out, 8'h00);
        chk("R6 pin3 reads pin", port_rd, 8'h08);
        tmr_cmp = 1'b1;
        pad_in = 8'h00;
        idle(3);
        chk("R5 pin3 drives timer high", pad_out, 8'h08);
        chk("R6 pin3 reads pin low", port_rd, 8'h00);

        // R7 / R8: serial data-in and clock pass-through
        wreg(2'd1, 8'h00);
        ser_en = 1'b1; ser_master = 1'b0;
        pad_in = 8'h05;
        idle(3);
        chk("R7 sdi high", {7'd0, ser_sdi}, 8'h01);
        chk("R8 sck in high", {7'd0, ser_sck_in}, 8'h01);
        chk("R8 slave clock input", pad_oe, 8'h02);
        pad_in = 8'h00;
        idle(3);
        chk("R7 sdi low", {7'd0, ser_sdi}, 8'h00);
        ser_en = 1'b0;
        idle(1);
        chk("R7 disabled pins follow dir", pad_oe, 8'h00);

        // R1: reset mid-run clears registers
        wreg(2'd1, 8'hFF);
        wreg(2'd2, 8'h0F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 oe after mid reset", pad_oe, 8'h00);
        chk("R1 pu after mid reset", pad_pu_en, 8'h00);
        rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        finish_run();
    end
endmodule